// File: doc/BRIEF.md
# Widening Outer-Product Tile Accumulator

This block multiplies two 512-bit integer operand vectors as an outer product and adds the resulting 16x16 grid of 32-bit sums into one of four 16x16 accumulator tiles. The operands are cut into 32-bit, 16-bit or 8-bit signed lanes. The narrower lanes widen into the 32-bit tile as a small matrix product. Each 32-bit group of the first operand forms one row of a 16xK block, and each 32-bit group of the second operand forms one column of a Kx16 block. K is 1, 2 or 4, so every tile cell takes a K-term dot product per step.

A step is offered with `in_valid` and accepted when `in_ready` is high. The arithmetic runs in three registered stages: operand capture, product grid, and tile add. Steps to different tiles can therefore be accepted on consecutive cycles. A step whose tile still has an accumulate in flight waits until that accumulate has been written. A zero command clears one tile or all tiles at a clock edge. A row port returns one 512-bit tile row one cycle after it is requested.

Top module: `opa_tile_accum`

## Requirements
- R1: After reset, every tile cell reads as zero, `in_ready` is high and `rd_valid` is low.
- R2: With `in_mode` = 0, cell (i,j) of the selected tile gains A[i]*B[j]. Lane n of an operand is bits [32n+31:32n].
- R3: With `in_mode` = 1, cell (i,j) gains A[2i]*B[2j] + A[2i+1]*B[2j+1]. Lane n of an operand is bits [16n+15:16n].
- R4: With `in_mode` = 2 or 3, cell (i,j) gains the sum over k=0..3 of A[4i+k]*B[4j+k]. Lane n of an operand is bits [8n+7:8n].
- R5: All lanes are signed two's complement. Products and sums wrap modulo 2^32 without saturation.
- R6: A step changes only the tile named by `in_tile`. The other tiles keep their contents.
- R7: Steps that target different tiles are accepted on consecutive cycles. A step accepted at edge e is visible to a row read captured at edge e+4, but not to one captured at edge e+3.
- R8: While an accumulate to tile T is in flight, `in_ready` is low for a step to T. Two back-to-back steps to the same tile are accepted four cycles apart.
- R9: A zero command (`zero_en`) clears tile `zero_tile`, or all tiles when `zero_all` is set, at one edge. Every accumulate still in flight to a cleared tile is discarded, including one that writes back at that same edge. Writebacks to tiles that are not cleared still take effect.
- R10: `in_ready` is low while a zero command in the same cycle targets `in_tile`.
- R11: One cycle after `rd_en`, `rd_valid` is high and `rd_data` holds row `rd_row` of tile `rd_tile`, with cell j at bits [32j+31:32j]. The data is the tile contents from before the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Step offered |
| in_ready | output | 1 | Step can be accepted this cycle |
| in_mode | input | 2 | Lane width: 0 = 32-bit, 1 = 16-bit, 2 or 3 = 8-bit |
| in_tile | input | 2 | Destination tile |
| in_a | input | 512 | Row operand vector |
| in_b | input | 512 | Column operand vector |
| zero_en | input | 1 | Zero command |
| zero_all | input | 1 | Zero command clears every tile |
| zero_tile | input | 2 | Tile cleared when `zero_all` is low |
| rd_en | input | 1 | Row read request |
| rd_tile | input | 2 | Tile to read |
| rd_row | input | 4 | Row to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 512 | Row contents, 16 x 32 bits |

## Verification
The case that needs most care is a zero command that lands on the same edge as a tile writeback. The bench issues a step to one tile and a second step to another tile. It then times a zero command so that it reaches the first tile exactly at its third edge after acceptance, when that tile's writeback happens. Both tiles are then read back. The cleared tile must be all zeros, and the neighbour tile must hold its sum. A second case lands a zero command on another tile's writeback edge and confirms that the writeback survives.

// File: rtl/opa_pkg.sv
package opa_pkg;

  // Lane interpretation of the operand vectors; 3 behaves like 2.
  typedef enum logic [1:0] {
    OPA_W32 = 2'd0,
    OPA_W16 = 2'd1,
    OPA_W8  = 2'd2,
    OPA_W8B = 2'd3
  } opa_mode_e;

endpackage

// File: rtl/opa_cell_dot.sv
module opa_cell_dot
  import opa_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  opa_mode_e          mode,
  input  logic [ACC_W-1:0]   a_grp,
  input  logic [ACC_W-1:0]   b_grp,
  output logic [ACC_W-1:0]   dot
);

  localparam int HW = ACC_W / 2;
  localparam int QW = ACC_W / 4;

  function automatic logic [ACC_W-1:0] sx_half(input logic [HW-1:0] v);
    return {{(ACC_W-HW){v[HW-1]}}, v};
  endfunction

  function automatic logic [ACC_W-1:0] sx_quart(input logic [QW-1:0] v);
    return {{(ACC_W-QW){v[QW-1]}}, v};
  endfunction

  logic [ACC_W-1:0] dot_full;
  logic [ACC_W-1:0] dot_half;
  logic [ACC_W-1:0] dot_quart;

  // Low product bits are sign-agnostic, so the full-width lane needs no extension.
  always_comb begin
    dot_full = a_grp * b_grp;
    dot_half = '0;
    for (int k = 0; k < 2; k++) begin
      dot_half = dot_half + sx_half(a_grp[k*HW +: HW]) * sx_half(b_grp[k*HW +: HW]);
    end
    dot_quart = '0;
    for (int k = 0; k < 4; k++) begin
      dot_quart = dot_quart + sx_quart(a_grp[k*QW +: QW]) * sx_quart(b_grp[k*QW +: QW]);
    end
    unique case (mode)
      OPA_W32: dot = dot_full;
      OPA_W16: dot = dot_half;
      default: dot = dot_quart;
    endcase
  end

endmodule

// File: rtl/opa_product_grid.sv
module opa_product_grid
  import opa_pkg::*;
#(
  parameter int LANES = 16,
  parameter int ACC_W = 32,
  localparam int OPND_W = LANES * ACC_W,
  localparam int GRID_W = LANES * LANES * ACC_W
) (
  input  opa_mode_e          mode,
  input  logic [OPND_W-1:0]  vec_a,
  input  logic [OPND_W-1:0]  vec_b,
  output logic [GRID_W-1:0]  grid
);

  // Cell (i,j) sits at flat index i*LANES+j; group i of A is row i, group j of B is column j.
  for (genvar i = 0; i < LANES; i++) begin : g_row
    for (genvar j = 0; j < LANES; j++) begin : g_col
      opa_cell_dot #(.ACC_W(ACC_W)) i_cell (
        .mode  (mode),
        .a_grp (vec_a[i*ACC_W +: ACC_W]),
        .b_grp (vec_b[j*ACC_W +: ACC_W]),
        .dot   (grid[(i*LANES + j)*ACC_W +: ACC_W])
      );
    end
  end

endmodule

// File: rtl/opa_tile_bank.sv
module opa_tile_bank #(
  parameter int NTILES = 4,
  parameter int LANES  = 16,
  parameter int ACC_W  = 32,
  localparam int TW       = $clog2(NTILES),
  localparam int RW       = $clog2(LANES),
  localparam int ROW_BITS = LANES * ACC_W,
  localparam int GRID_W   = LANES * ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTILES-1:0]   clr_mask,
  input  logic                wr_en,
  input  logic [TW-1:0]       wr_tile,
  input  logic [GRID_W-1:0]   wr_data,
  input  logic [TW-1:0]       peek_tile,
  output logic [GRID_W-1:0]   peek_data,
  input  logic                rd_en,
  input  logic [TW-1:0]       rd_tile,
  input  logic [RW-1:0]       rd_row,
  output logic                rd_valid,
  output logic [ROW_BITS-1:0] rd_data
);

  logic [GRID_W-1:0]   mem_q [NTILES];
  logic [GRID_W-1:0]   mem_d [NTILES];
  logic                rd_valid_q;
  logic [ROW_BITS-1:0] rd_data_q;
  logic [ROW_BITS-1:0] rd_data_d;

  // Clear beats a writeback to the same tile.
  always_comb begin
    for (int t = 0; t < NTILES; t++) begin
      mem_d[t] = mem_q[t];
      if (clr_mask[t]) begin
        mem_d[t] = '0;
      end else if (wr_en && (wr_tile == TW'(t))) begin
        mem_d[t] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTILES; t++) mem_q[t] <= '0;
    end else begin
      for (int t = 0; t < NTILES; t++) mem_q[t] <= mem_d[t];
    end
  end

  assign rd_data_d = mem_q[rd_tile][int'(rd_row)*ROW_BITS +: ROW_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data_q <= rd_data_d;
  end

  assign peek_data = mem_q[peek_tile];
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

  for (genvar t = 0; t < NTILES; t++) begin : g_chk
    AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[t] |=> (mem_q[t] == '0)) else $error("tile not cleared"); // R9
    AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_mask[t] && !(wr_en && (wr_tile == TW'(t)))) |=> $stable(mem_q[t]))
      else $error("tile changed without write"); // R6
  end

endmodule

// File: rtl/opa_tile_accum.sv
module opa_tile_accum
  import opa_pkg::*;
#(
  parameter int NTILES = 4,
  parameter int LANES  = 16,
  parameter int ACC_W  = 32,
  localparam int TW     = $clog2(NTILES),
  localparam int RW     = $clog2(LANES),
  localparam int OPND_W = LANES * ACC_W,
  localparam int GRID_W = LANES * OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [TW-1:0]     in_tile,
  input  logic [OPND_W-1:0] in_a,
  input  logic [OPND_W-1:0] in_b,
  input  logic              zero_en,
  input  logic              zero_all,
  input  logic [TW-1:0]     zero_tile,
  input  logic              rd_en,
  input  logic [TW-1:0]     rd_tile,
  input  logic [RW-1:0]     rd_row,
  output logic              rd_valid,
  output logic [OPND_W-1:0] rd_data
);

  // Stage 1: operands captured
  logic              s1_v_q, s1_v_d;
  opa_mode_e         s1_mode_q;
  logic [TW-1:0]     s1_tile_q;
  logic [OPND_W-1:0] s1_a_q, s1_b_q;
  // Stage 2: product grid
  logic              s2_v_q, s2_v_d;
  logic [TW-1:0]     s2_tile_q;
  logic [GRID_W-1:0] s2_prod_q, prod_grid;
  // Stage 3: tile sum awaiting writeback
  logic              s3_v_q, s3_v_d;
  logic [TW-1:0]     s3_tile_q;
  logic [GRID_W-1:0] s3_sum_q, s3_sum_d;

  logic [NTILES-1:0] clr_mask;
  logic [NTILES-1:0] tile_busy;
  logic [GRID_W-1:0] tile_now;
  logic              fire;
  logic              wb_en;

  for (genvar t = 0; t < NTILES; t++) begin : g_tile
    assign clr_mask[t]  = zero_en && (zero_all || (zero_tile == TW'(t)));
    assign tile_busy[t] = (s1_v_q && (s1_tile_q == TW'(t))) ||
                          (s2_v_q && (s2_tile_q == TW'(t))) ||
                          (s3_v_q && (s3_tile_q == TW'(t)));
    AST_ONE_INFLIGHT_PER_TILE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({s1_v_q && (s1_tile_q == TW'(t)),
                  s2_v_q && (s2_tile_q == TW'(t)),
                  s3_v_q && (s3_tile_q == TW'(t))}) <= 1)
      else $error("two accumulates in flight to one tile"); // R8
  end

  assign in_ready = !tile_busy[in_tile] && !clr_mask[in_tile];
  assign fire     = in_valid && in_ready;

  // Entries to a tile being cleared are dropped at the clearing edge.
  always_comb begin
    s1_v_d = fire;
    s2_v_d = s1_v_q && !clr_mask[s1_tile_q];
    s3_v_d = s2_v_q && !clr_mask[s2_tile_q];
    wb_en  = s3_v_q && !clr_mask[s3_tile_q];
  end

  opa_product_grid #(.LANES(LANES), .ACC_W(ACC_W)) i_grid (
    .mode  (s1_mode_q),
    .vec_a (s1_a_q),
    .vec_b (s1_b_q),
    .grid  (prod_grid)
  );

  for (genvar c = 0; c < LANES*LANES; c++) begin : g_add
    assign s3_sum_d[c*ACC_W +: ACC_W] = tile_now[c*ACC_W +: ACC_W] + s2_prod_q[c*ACC_W +: ACC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
      s3_v_q <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d;
      s2_v_q <= s2_v_d;
      s3_v_q <= s3_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      s1_mode_q <= opa_mode_e'(in_mode);
      s1_tile_q <= in_tile;
      s1_a_q    <= in_a;
      s1_b_q    <= in_b;
    end
    if (s1_v_q) begin
      s2_tile_q <= s1_tile_q;
      s2_prod_q <= prod_grid;
    end
    if (s2_v_q) begin
      s3_tile_q <= s2_tile_q;
      s3_sum_q  <= s3_sum_d;
    end
  end

  opa_tile_bank #(.NTILES(NTILES), .LANES(LANES), .ACC_W(ACC_W)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_mask  (clr_mask),
    .wr_en     (wb_en),
    .wr_tile   (s3_tile_q),
    .wr_data   (s3_sum_q),
    .peek_tile (s2_tile_q),
    .peek_data (tile_now),
    .rd_en     (rd_en),
    .rd_tile   (rd_tile),
    .rd_row    (rd_row),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  AST_ACCEPT_ENTERS_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_v_q) else $error("accepted step lost"); // R7
  AST_IDLE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!s1_v_q && !s2_v_q && !s3_v_q && !zero_en) |-> in_ready)
    else $error("stall with empty pipeline"); // R7
  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid) else $error("read not answered"); // R11

endmodule

// File: tb/test_opa_tile_accum.sv
module test_opa_tile_accum;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   in_mode;
  logic [1:0]   in_tile;
  logic [511:0] in_a, in_b;
  logic         zero_en, zero_all;
  logic [1:0]   zero_tile;
  logic         rd_en;
  logic [1:0]   rd_tile;
  logic [3:0]   rd_row;
  logic         rd_valid;
  logic [511:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [511:0] row;
    string        tag;
  } rd_exp_t;
  rd_exp_t exp_q[$];

  int mdl [4][16][16];

  always #(CLK_PERIOD/2) clk = ~clk;

  opa_tile_accum i_opa_tile_accum (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode), .in_tile(in_tile),
    .in_a(in_a), .in_b(in_b),
    .zero_en(zero_en), .zero_all(zero_all), .zero_tile(zero_tile),
    .rd_en(rd_en), .rd_tile(rd_tile), .rd_row(rd_row),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check_eq(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int cell_val(input int mode, input logic [511:0] a, input logic [511:0] b,
                                  input int i, input int j);
    int s;
    s = 0;
    if (mode == 0) begin
      s = int'(a[32*i +: 32]) * int'(b[32*j +: 32]);
    end else if (mode == 1) begin
      for (int k = 0; k < 2; k++)
        s += int'($signed(a[16*(2*i+k) +: 16])) * int'($signed(b[16*(2*j+k) +: 16]));
    end else begin
      for (int k = 0; k < 4; k++)
        s += int'($signed(a[8*(4*i+k) +: 8])) * int'($signed(b[8*(4*j+k) +: 8]));
    end
    return s;
  endfunction

  function automatic logic [511:0] mdl_row(input int t, input int r);
    logic [511:0] v;
    for (int j = 0; j < 16; j++) v[32*j +: 32] = mdl[t][r][j];
    return v;
  endfunction

  function automatic logic [511:0] rvec();
    logic [511:0] v;
    for (int w = 0; w < 16; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  task automatic mdl_zero(input int t);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) mdl[t][i][j] = 0;
  endtask

  task automatic step(input int mode, input int t, input logic [511:0] a, input logic [511:0] b,
                      output realtime acc);
    @(negedge clk);
    in_mode = mode[1:0]; in_tile = t[1:0]; in_a = a; in_b = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    acc = $realtime;
    #1 in_valid = 1'b0;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) mdl[t][i][j] += cell_val(mode, a, b, i, j);
  endtask

  task automatic zero_cmd(input bit all, input int t, input int delay);
    repeat (delay) @(posedge clk);
    @(negedge clk);
    zero_en = 1'b1; zero_all = all; zero_tile = t[1:0];
    @(posedge clk);
    #1 zero_en = 1'b0;
    if (all) for (int k = 0; k < 4; k++) mdl_zero(k);
    else mdl_zero(t);
  endtask

  task automatic rd(input int t, input int r, input int delay, input logic [511:0] exp,
                    input string tag);
    rd_exp_t e;
    repeat (delay) @(posedge clk);
    @(negedge clk);
    rd_en = 1'b1; rd_tile = t[1:0]; rd_row = r[3:0];
    e.row = exp; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic drain();
    repeat (6) @(posedge clk);
  endtask

  task automatic dump(input string tag);
    drain();
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 16; r++) rd(t, r, 0, mdl_row(t, r), tag);
    drain();
  endtask

  // Monitor: every returned row is compared with the next expected one.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R11 unexpected rd_valid actual=1 expected=0");
      end else begin
        rd_exp_t e;
        e = exp_q.pop_front();
        check_eq(e.tag, rd_data, e.row);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    realtime ta, tb, tc, td;
    logic [511:0] a, b, old_row, new_row;

    rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_tile = '0; in_a = '0; in_b = '0;
    zero_en = 1'b0; zero_all = 1'b0; zero_tile = '0; rd_en = 1'b0; rd_tile = '0; rd_row = '0;
    for (int k = 0; k < 4; k++) mdl_zero(k);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check_eq("R1 in_ready after reset", {511'b0, in_ready}, 512'd1);
    check_eq("R1 rd_valid after reset", {511'b0, rd_valid}, 512'd0);
    dump("R1 tile zero after reset");

    // R2, R5: 0x7fffffff squared wraps to 1
    a = {16{32'h7fffffff}};
    step(0, 0, a, a, ta);
    // R3: -32768*32767 twice per cell
    step(1, 3, {32{16'h8000}}, {32{16'h7fff}}, ta);
    // R4: -128*-128 four times per cell, modes 2 and 3
    step(2, 1, {64{8'h80}}, {64{8'h80}}, ta);
    step(3, 2, {64{8'h80}}, {64{8'h80}}, ta);
    drain();
    rd(0, 7, 0, {16{32'h00000001}}, "R5 wrap 32-bit");
    rd(3, 2, 0, {16{32'h80010000}}, "R3 16-bit pair sum");
    rd(1, 15, 0, {16{32'h00010000}}, "R4 8-bit quad sum");
    rd(2, 0, 0, {16{32'h00010000}}, "R4 mode 3 as 8-bit");
    // R6: every tile compared, only targeted ones changed
    dump("R6 R2 R3 R4 directed tiles");

    // R2: mode 0 with distinct lanes
    a = rvec(); b = rvec();
    step(0, 2, a, b, ta);
    dump("R2 32-bit random");

    // R7: different tiles on consecutive cycles
    step(2, 0, rvec(), rvec(), ta);
    step(1, 1, rvec(), rvec(), tb);
    step(0, 2, rvec(), rvec(), tc);
    step(2, 3, rvec(), rvec(), td);
    check_eq("R7 accept spacing 0-1", 512'((tb - ta) / CLK_PERIOD), 512'd1);
    check_eq("R7 accept spacing 1-2", 512'((tc - tb) / CLK_PERIOD), 512'd1);
    check_eq("R7 accept spacing 2-3", 512'((td - tc) / CLK_PERIOD), 512'd1);
    dump("R7 pipelined tiles");

    // R7, R11: visibility edge of a step
    old_row = mdl_row(3, 5);
    step(0, 3, rvec(), rvec(), ta);
    new_row = mdl_row(3, 5);
    rd(3, 5, 2, old_row, "R7 R11 read at third edge sees old");
    rd(3, 5, 0, new_row, "R7 read at fourth edge sees sum");
    drain();

    // R8: same tile back to back
    step(1, 2, rvec(), rvec(), ta);
    step(1, 2, rvec(), rvec(), tb);
    check_eq("R8 same-tile spacing", 512'((tb - ta) / CLK_PERIOD), 512'd4);
    dump("R8 same tile sums");

    // R10: zero aimed at in_tile holds off issue
    @(negedge clk);
    zero_en = 1'b1; zero_all = 1'b0; zero_tile = 2'd1; in_tile = 2'd1;
    #1 check_eq("R10 ready low for zeroed tile", {511'b0, in_ready}, 512'd0);
    in_tile = 2'd0;
    #1 check_eq("R10 ready high for other tile", {511'b0, in_ready}, 512'd1);
    @(posedge clk);
    #1 zero_en = 1'b0;
    mdl_zero(1);
    dump("R9 R10 single zero");

    // R9: zero lands on tile 1 writeback edge; tile 0 writeback follows
    step(0, 0, rvec(), rvec(), ta);
    dump("R9 setup");
    step(2, 1, rvec(), rvec(), ta);
    step(1, 0, rvec(), rvec(), tb);
    zero_cmd(1'b0, 1, 1);
    dump("R9 zero wins same-edge writeback");

    // R9: zero of tile 2 on tile 0 writeback edge leaves tile 0 written
    step(2, 2, rvec(), rvec(), ta);
    drain();
    step(0, 0, rvec(), rvec(), ta);
    zero_cmd(1'b0, 2, 2);
    dump("R9 other-tile writeback survives");

    // R9: zero all mid-flight, then accumulate again
    step(1, 3, rvec(), rvec(), ta);
    zero_cmd(1'b1, 0, 0);
    dump("R9 zero all discards in-flight");
    step(2, 3, rvec(), rvec(), ta);
    dump("R9 accumulate after zero");

    // Random sequences over all modes and tiles
    for (int n = 0; n < 60; n++) begin
      step(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), rvec(), rvec(), ta);
    end
    dump("R2 R3 R4 R5 R6 random mix");

    drain();
    check_eq("R11 no read left pending", 512'(exp_q.size()), 512'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule